// File: doc/BRIEF.md
# Calibrated BCD Calendar Clock

This block keeps wall-clock time and a calendar as packed BCD counters (seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and century). It advances from a single-cycle tick enable that pulses at 32768 Hz. A prescaler divides that tick down to one pulse per second, and a ripple-carry chain carries the pulse through the calendar fields. Month lengths and leap years are handled in hardware.

Software does not read the counters directly. It reads a second set of holding registers, which are refreshed from the counters once per second in a single cycle. A read-halt bit freezes the holding registers so that a consistent snapshot can be read while the counters keep running. A write-set bit also freezes them. While it is set, software loads new time values into the holding registers, and clearing the bit copies them all into the counters at once.

The rate is trimmed without touching the oscillator. Once per minute, one second is lengthened or shortened at the divide-by-256 stage of the prescaler. The number of corrected minutes in a repeating 64-minute cycle is programmable. A 512 Hz test square wave taken ahead of the correction lets the crystal be measured. A stop bit freezes the whole timebase.

Top module: `rtcCalendarClock`

## Requirements
- R1: Register addresses are: 0 control, 1 seconds (bit 7 = stop), 2 minutes, 3 hours, 4 day (bit 6 = test enable, bits 2:0 = day 1-7), 5 date, 6 month, 7 year, 8 century. Seconds and minutes count 00-59 in BCD, and hours count 00-23. Seconds 59 carries into minutes, minutes 59 into hours, and 23:59:59 rolls to 00:00:00.
- R2: A day carry steps the day of week (7 wraps to 1) and the date. The date wraps to 01 after the month's last day: 28 or 29 for month 02, 30 for months 04, 06, 09 and 11, and 31 otherwise. A year whose BCD value is divisible by 4 (00 included) is a leap year. Month 12 wraps to 01 and steps the year, and year 99 wraps to 00 and steps the century.
- R3: Control bit 6 (read-halt) at 1 keeps the holding registers at the values they had when the bit was set, while the counters keep counting. After the bit returns to 0, the next one-second refresh shows the counted time.
- R4: Control bit 7 (write-set) at 1 stops refreshes, so values written to time registers are held. Writing control with bit 7 = 0 while it is 1 loads every holding value into the counters in one cycle and restarts the prescaler, so the next refresh comes one full second later.
- R5: A refresh is a single-cycle copy of all fields. A halt written in the same cycle as a refresh does not cancel that refresh.
- R6: Seconds bit 7 (stop) at 1 freezes timekeeping and the test output. Clearing it restarts counting, and the first second after the restart is a full second. The stop bit and the test-enable bit are written directly, without the write-set bit.
- R7: Control bits 4:0 hold a calibration magnitude N, and bit 5 holds its sign. In a corrected second, a sign of 1 shortens the second by half a prescaler stage (128 ticks by default) and a sign of 0 lengthens it by one full stage (256 ticks).
- R8: Corrections repeat over a 64-minute cycle that restarts when time is loaded. The second :00 of each of minutes 0 to 2N-1 of the cycle is corrected, which is at most 62 minutes.
- R9: With stop at 0 and test-enable at 1, ftOut is a square wave of tick/64 (512 Hz at 32768 Hz), and its period does not depend on the calibration setting. Otherwise ftOut is 0.
- R10: After reset, control reads 0x00 (read-halt, write-set, test-enable and calibration cleared), seconds reads 0x80 (stopped at 00), and date and month read 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle timebase tick enable (32768 Hz nominal) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Read data of the addressed register (combinational) |
| ftOut | output | 1 | Frequency-test square wave |

## Verification
The calendar chain is tried with starting dates chosen to separate the cases: a leap February, a non-leap February, a year-00 February, a 30-day month and a century wrap at 99-12-31. Each of these can only pass if the matching month-length or carry decision is right. Freeze and load are checked at tick counts placed on either side of the one-second refresh. This tells apart "frozen", "counters kept running" and "restarted by the load". The calibration is judged by measuring minute lengths in cycles. The positive setting is checked at the edge of the 2N window, and the negative setting is checked over a full 64-minute cycle, so the sign, the size of a correction and the window length each show up in a different number.

// File: rtl/rtcPkg.sv
package rtcPkg;

  localparam int ADDR_W     = 4;
  localparam int NUM_FIELDS = 7;

  // field indices of the ripple chain, in carry order
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_YEAR  = 5;
  localparam int F_CENT  = 6;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_SEC   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_MIN   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_HOUR  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_DAY   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_DATE  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_MONTH = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_YEAR  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_CENT  = 4'd8;

  typedef struct packed {
    logic secTick;   // advance the counters by one second
    logic refresh;   // copy counters into holding registers
    logic transfer;  // copy holding registers into counters
  } rtcStrobes_t;

  function automatic logic [ADDR_W-1:0] fieldAddr(input int idx);
    case (idx)
      F_SEC:   return ADR_SEC;
      F_MIN:   return ADR_MIN;
      F_HOUR:  return ADR_HOUR;
      F_DATE:  return ADR_DATE;
      F_MONTH: return ADR_MONTH;
      F_YEAR:  return ADR_YEAR;
      default: return ADR_CENT;
    endcase
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      F_SEC, F_MIN:    return 8'h7F;
      F_HOUR, F_DATE:  return 8'h3F;
      F_MONTH:         return 8'h1F;
      default:         return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fieldLimit(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DATE:       return 8'h31;
      F_MONTH:      return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] fieldFirst(input int idx);
    return (idx == F_DATE || idx == F_MONTH) ? 8'h01 : 8'h00;
  endfunction

  // BCD year divisible by four
  function automatic logic bcdIsLeap(input logic [7:0] y);
    logic [3:0] ones;
    ones = y[3:0];
    if (!y[4]) return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    return (ones == 4'd2) || (ones == 4'd6);
  endfunction

  function automatic logic [7:0] monthLastDay(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                     return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcBcdField.sv
module rtcBcdField #(
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] loadVal,
  input  logic [7:0] limit,
  input  logic [7:0] first,
  output logic [7:0] value,
  output logic       wrap
);

  logic [7:0] nextVal;

  assign wrap = step && (value == limit);

  always_comb begin
    if (value[3:0] == 4'd9) nextVal = {value[7:4] + 4'd1, 4'd0};
    else                    nextVal = {value[7:4], value[3:0] + 4'd1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     value <= RESET_VAL;
    else if (load) value <= loadVal;
    else if (wrap) value <= first;
    else if (step) value <= nextVal;
  end

endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath import rtcPkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        ctrlByte,
  input  logic              stopBit,
  input  logic              ftBit,
  output logic [7:0]        rdData,
  output logic              secIsZero,
  output logic              minuteWrap
);

  logic [NUM_FIELDS-1:0][7:0] cnt;
  logic [NUM_FIELDS-1:0][7:0] hold;
  logic [NUM_FIELDS-1:0]      wrapF;
  logic [7:0]                 lastDay;
  logic [2:0]                 cntDay;
  logic [2:0]                 holdDay;

  assign lastDay    = monthLastDay(cnt[F_MONTH], bcdIsLeap(cnt[F_YEAR]));
  assign secIsZero  = (cnt[F_SEC] == 8'h00);
  assign minuteWrap = wrapF[F_SEC];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gField
    logic [7:0] lim;
    logic       stp;
    logic [7:0] holdQ;
    logic       holdWr;

    if (i == F_DATE) begin : gDyn
      assign lim = lastDay;
    end else begin : gFix
      assign lim = fieldLimit(i);
    end

    if (i == 0) begin : gHead
      assign stp = strb.secTick;
    end else begin : gLink
      assign stp = wrapF[i-1];
    end

    rtcBcdField #(.RESET_VAL(fieldFirst(i))) uField (
      .clk     (clk),
      .rstN    (rstN),
      .step    (stp),
      .load    (strb.transfer),
      .loadVal (holdQ),
      .limit   (lim),
      .first   (fieldFirst(i)),
      .value   (cnt[i]),
      .wrap    (wrapF[i])
    );

    assign holdWr = wrEn && (addr == fieldAddr(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             holdQ <= fieldFirst(i);
      else if (holdWr)       holdQ <= wrData & fieldMask(i);
      else if (strb.refresh) holdQ <= cnt[i];
    end

    assign hold[i] = holdQ;
  end

  // day of week, stepped by the day carry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cntDay <= 3'd1;
    else if (strb.transfer)    cntDay <= holdDay;
    else if (wrapF[F_HOUR])    cntDay <= (cntDay == 3'd7) ? 3'd1 : cntDay + 3'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            holdDay <= 3'd1;
    else if (wrEn && addr == ADR_DAY)     holdDay <= wrData[2:0];
    else if (strb.refresh)                holdDay <= cntDay;
  end

  always_comb begin
    rdData = 8'h00;
    if (addr == ADR_CTRL) rdData = ctrlByte;
    if (addr == ADR_DAY)  rdData = {1'b0, ftBit, 3'b000, holdDay};
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (addr == fieldAddr(i)) rdData = hold[i];
    end
    if (addr == ADR_SEC)  rdData = {stopBit, hold[F_SEC][6:0]};
  end

  // seconds 59 rolls back to 00 on the next tick
  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.secTick && !strb.transfer && cnt[F_SEC] == 8'h59) |=> (cnt[F_SEC] == 8'h00));

  // a date carry restarts the date at 01 and moves the month
  assert_date_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrapF[F_DATE] && !strb.transfer) |=> (cnt[F_DATE] == 8'h01 && cnt[F_MONTH] != $past(cnt[F_MONTH])));

  // a halted copy only changes by an explicit write
  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlByte[7] || ctrlByte[6]) && !wrEn) |=> $stable(hold));

  // a refresh takes all fields from the counters at once
  assert_refresh_whole_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refresh && !wrEn) |=> (hold == $past(cnt)));

endmodule

// File: rtl/rtcControl.sv
module rtcControl import rtcPkg::*; #(
  parameter int LOW_BITS  = 8,
  parameter int HIGH_BITS = 7,
  parameter int FT_BITS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              secIsZero,
  input  logic              minuteWrap,
  output rtcStrobes_t       strb,
  output logic [7:0]        ctrlByte,
  output logic              stopBit,
  output logic              ftBit,
  output logic              ftOut
);

  localparam int STAGE = 1 << LOW_BITS;
  localparam int LOW_W = LOW_BITS + 1;
  localparam int NOM   = STAGE << HIGH_BITS;
  localparam int LEN_W = LOW_BITS + HIGH_BITS + 2;
  localparam logic [LOW_W-1:0]     LIM_NORM = LOW_W'(STAGE - 1);
  localparam logic [LOW_W-1:0]     LIM_FAST = LOW_W'(STAGE / 2 - 1);
  localparam logic [LOW_W-1:0]     LIM_SLOW = LOW_W'(2 * STAGE - 1);
  localparam logic [HIGH_BITS-1:0] HI_LAST  = '1;

  logic                 writeBit, readBit, calSign;
  logic [4:0]           calMag;
  logic [LOW_W-1:0]     lowCnt, lowLimit;
  logic [HIGH_BITS-1:0] hiCnt;
  logic [FT_BITS-1:0]   ftCnt;
  logic [5:0]           calMin;
  logic                 correctNow, stageEnd, secTick, transfer, refreshQ;
  logic                 ctrlWr;

  assign ctrlWr   = wrEn && (addr == ADR_CTRL);
  assign transfer = ctrlWr && writeBit && !wrData[7];
  assign ctrlByte = {writeBit, readBit, calSign, calMag};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeBit <= 1'b0;
      readBit  <= 1'b0;
      calSign  <= 1'b0;
      calMag   <= 5'd0;
      stopBit  <= 1'b1;
      ftBit    <= 1'b0;
    end else begin
      if (ctrlWr) {writeBit, readBit, calSign, calMag} <= wrData;
      if (wrEn && addr == ADR_SEC) stopBit <= wrData[7];
      if (wrEn && addr == ADR_DAY) ftBit   <= wrData[6];
    end
  end

  // calibration: one second per minute in the first 2N minutes of 64
  assign correctNow = secIsZero && (hiCnt == '0) && (calMin < {calMag, 1'b0});

  always_comb begin
    lowLimit = LIM_NORM;
    if (correctNow) lowLimit = calSign ? LIM_FAST : LIM_SLOW;
  end

  assign stageEnd = (lowCnt == lowLimit);
  assign secTick  = tickIn && !stopBit && !transfer && stageEnd && (hiCnt == HI_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      hiCnt  <= '0;
    end else if (stopBit || transfer) begin
      lowCnt <= '0;
      hiCnt  <= '0;
    end else if (tickIn) begin
      if (stageEnd) begin
        lowCnt <= '0;
        hiCnt  <= hiCnt + 1'b1;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                calMin <= '0;
    else if (transfer)        calMin <= '0;
    else if (minuteWrap)      calMin <= calMin + 6'd1;
  end

  // test output divides the raw tick, ahead of any correction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ftCnt <= '0;
    else if (stopBit) ftCnt <= '0;
    else if (tickIn)  ftCnt <= ftCnt + 1'b1;
  end

  assign ftOut = ftBit && !stopBit && ftCnt[FT_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refreshQ <= 1'b0;
    else       refreshQ <= secTick;
  end

  always_comb begin
    strb          = '0;
    strb.secTick  = secTick;
    strb.transfer = transfer;
    strb.refresh  = refreshQ && !readBit && !writeBit;
  end

  // checker: length of each second in ticks
  logic [LEN_W-1:0] secLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       secLen <= '0;
    else if (stopBit || transfer)    secLen <= '0;
    else if (secTick)                secLen <= '0;
    else if (tickIn)                 secLen <= secLen + 1'b1;
  end

  assert_sec_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> ((secLen + 1'b1 == LEN_W'(NOM)) ||
                 (secLen + 1'b1 == LEN_W'(NOM - STAGE / 2)) ||
                 (secLen + 1'b1 == LEN_W'(NOM + STAGE))));

  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> (lowCnt == '0 && hiCnt == '0 && !ftOut));

  assert_load_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    transfer |=> (lowCnt == '0 && hiCnt == '0 && calMin == '0));

  assert_window_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (correctNow && tickIn && !stopBit) |-> (calMin < 6'd62));

endmodule

// File: rtl/rtcCalendarClock.sv
module rtcCalendarClock import rtcPkg::*; #(
  parameter int LOW_BITS  = 8,
  parameter int HIGH_BITS = 7,
  parameter int FT_BITS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              ftOut
);

  rtcStrobes_t strb;
  logic [7:0]  ctrlByte;
  logic        stopBit, ftBit, secIsZero, minuteWrap;

  rtcControl #(
    .LOW_BITS  (LOW_BITS),
    .HIGH_BITS (HIGH_BITS),
    .FT_BITS   (FT_BITS)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickIn     (tickIn),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .secIsZero  (secIsZero),
    .minuteWrap (minuteWrap),
    .strb       (strb),
    .ctrlByte   (ctrlByte),
    .stopBit    (stopBit),
    .ftBit      (ftBit),
    .ftOut      (ftOut)
  );

  rtcDatapath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .ctrlByte   (ctrlByte),
    .stopBit    (stopBit),
    .ftBit      (ftBit),
    .rdData     (rdData),
    .secIsZero  (secIsZero),
    .minuteWrap (minuteWrap)
  );

endmodule

// File: tb/tb_rtcCalendarClock.sv
`timescale 1ns/1ps
module tb_rtcCalendarClock;

  // shrunken prescaler: 4-tick stage, 16-tick second
  localparam int LB = 2;
  localparam int HB = 2;
  localparam int SEC_T   = 16;
  localparam int MIN_T   = 60 * SEC_T;
  localparam int FAST_D  = 2;   // half stage
  localparam int SLOW_D  = 4;   // one stage

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       ftOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtcCalendarClock #(.LOW_BITS(LB), .HIGH_BITS(HB), .FT_BITS(6)) dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .ftOut(ftOut)
  );

  // scoreboard
  typedef struct { logic [7:0] exp; string tag; logic [3:0] a; } item_t;
  item_t q[$];
  logic  sampleNow = 1'b0;

  always @(negedge clk) begin
    if (sampleNow && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rdData !== it.exp) begin
        errors++;
        $display("FAIL %s addr %0d actual=%02h expected=%02h", it.tag, it.a, rdData, it.exp);
      end
    end
  end

  task automatic checkReg(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.exp = e; it.tag = tag; it.a = a;
    q.push_back(it);
    sampleNow = 1'b1;
    @(negedge clk); #1;
    sampleNow = 1'b0;
  endtask

  task automatic score(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n);
    tickIn = 1'b1;
    repeat (n) @(posedge clk);
    #1 tickIn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] cal, input logic [7:0] cent, input logic [7:0] yr,
                         input logic [7:0] mon, input logic [7:0] dt, input logic [7:0] dy,
                         input logic [7:0] hr, input logic [7:0] mn, input logic [7:0] sc);
    wr(4'd0, {2'b10, cal[5:0]});
    wr(4'd8, cent); wr(4'd7, yr); wr(4'd6, mon); wr(4'd5, dt);
    wr(4'd4, dy);   wr(4'd3, hr); wr(4'd2, mn);  wr(4'd1, sc);
    wr(4'd0, {2'b00, cal[5:0]});
  endtask

  // cycle stamps of minute-register changes, ticking continuously
  int stamp [0:70];
  task automatic measureMinutes(input int n);
    logic [7:0] prev;
    int k;
    @(posedge clk); #1;
    addr = 4'd2;
    tickIn = 1'b1;
    @(negedge clk);
    prev = rdData;
    k = 0;
    while (k < n) begin
      @(negedge clk);
      if (rdData != prev) begin
        stamp[k] = cyc;
        k++;
        prev = rdData;
      end
    end
    #1 tickIn = 1'b0;
  endtask

  task automatic measureFt(output int period);
    int t0;
    logic prev;
    tickIn = 1'b1;
    @(negedge clk); prev = ftOut;
    while (!(prev == 1'b0 && ftOut == 1'b1)) begin prev = ftOut; @(negedge clk); end
    t0 = cyc;
    prev = ftOut;
    @(negedge clk);
    while (!(prev == 1'b0 && ftOut == 1'b1)) begin prev = ftOut; @(negedge clk); end
    period = cyc - t0;
    #1 tickIn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per;
    int highs;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    checkReg(4'd0, 8'h00, "R10 control");
    checkReg(4'd1, 8'h80, "R10 seconds+stop");
    checkReg(4'd5, 8'h01, "R10 date");
    checkReg(4'd6, 8'h01, "R10 month");
    checkReg(4'd4, 8'h01, "R10 day/test bit");

    // R1 / R2 leap February, day wrap 7->1
    setTime(8'h00, 8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    runTicks(40);
    checkReg(4'd1, 8'h00, "R1 seconds rolled");
    checkReg(4'd2, 8'h00, "R1 minutes rolled");
    checkReg(4'd3, 8'h00, "R1 hours rolled");
    checkReg(4'd5, 8'h29, "R2 leap date");
    checkReg(4'd6, 8'h02, "R2 leap month");
    checkReg(4'd4, 8'h01, "R2 day of week wrap");

    // R2 non-leap February
    setTime(8'h00, 8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    runTicks(24);
    checkReg(4'd5, 8'h01, "R2 non-leap date");
    checkReg(4'd6, 8'h03, "R2 non-leap month");
    checkReg(4'd4, 8'h04, "R2 day step");

    // R2 year 00 is leap
    setTime(8'h00, 8'h21, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    runTicks(24);
    checkReg(4'd5, 8'h29, "R2 year00 leap date");

    // R2 30-day month
    setTime(8'h00, 8'h20, 8'h23, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    runTicks(24);
    checkReg(4'd5, 8'h01, "R2 30-day date");
    checkReg(4'd6, 8'h05, "R2 30-day month");

    // R2 century wrap
    setTime(8'h00, 8'h19, 8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    runTicks(24);
    checkReg(4'd8, 8'h20, "R2 century step");
    checkReg(4'd7, 8'h00, "R2 year wrap");
    checkReg(4'd6, 8'h01, "R2 month wrap");
    checkReg(4'd5, 8'h01, "R2 date wrap");

    // R3 read halt: counters keep running
    setTime(8'h00, 8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h10);
    runTicks(8);
    wr(4'd0, 8'h40);
    runTicks(40);
    checkReg(4'd1, 8'h10, "R3 frozen");
    wr(4'd0, 8'h00);
    runTicks(10);
    checkReg(4'd1, 8'h10, "R3 waits for refresh");
    runTicks(8);
    checkReg(4'd1, 8'h14, "R3 counted during halt");

    // R4 write-set and transfer
    wr(4'd0, 8'h80);
    wr(4'd1, 8'h30);
    runTicks(40);
    checkReg(4'd1, 8'h30, "R4 held while set");
    wr(4'd0, 8'h00);
    runTicks(15);
    checkReg(4'd1, 8'h30, "R4 full second after load");
    runTicks(2);
    checkReg(4'd1, 8'h31, "R4 first update after load");

    // R5 halt in the refresh cycle does not cancel it
    setTime(8'h00, 8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h40);
    runTicks(16);
    wr(4'd0, 8'h40);
    checkReg(4'd1, 8'h41, "R5 refresh completed");
    checkReg(4'd0, 8'h40, "R5 halt taken");
    wr(4'd0, 8'h00);

    // R6 stop bit
    setTime(8'h00, 8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h20);
    runTicks(8);
    wr(4'd1, 8'hA0);
    wr(4'd4, 8'h41);
    runTicks(40);
    checkReg(4'd1, 8'hA0, "R6 stopped");
    highs = 0;
    tickIn = 1'b1;
    for (int i = 0; i < 70; i++) begin @(negedge clk); if (ftOut) highs++; end
    #1 tickIn = 1'b0;
    score("R6 test output quiet while stopped", highs, 0);
    wr(4'd1, 8'h20);
    runTicks(15);
    checkReg(4'd1, 8'h20, "R6 restart full second");
    runTicks(2);
    checkReg(4'd1, 8'h21, "R6 counting again");

    // R9 test output
    checkReg(4'd4, 8'h41, "R9 test bit readback");
    measureFt(per);
    score("R9 period", per, 64);
    wr(4'd0, 8'h3F);
    measureFt(per);
    score("R9 period with calibration", per, 64);

    // R7 / R8 positive, N=1
    setTime(8'h21, 8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h00);
    measureMinutes(3);
    score("R7 shortened minute", stamp[1] - stamp[0], MIN_T - FAST_D);
    score("R8 minute 2N uncorrected", stamp[2] - stamp[1], MIN_T);

    // R7 / R8 negative, N=31, whole cycle
    setTime(8'h1F, 8'h20, 8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h00);
    measureMinutes(65);
    score("R7 lengthened minute", stamp[1] - stamp[0], MIN_T + SLOW_D);
    score("R8 minute 62 uncorrected", stamp[62] - stamp[61], MIN_T);
    score("R8 minute 63 uncorrected", stamp[63] - stamp[62], MIN_T);
    score("R8 cycle repeats", stamp[64] - stamp[63], MIN_T + SLOW_D);
    score("R8 64-minute cycle length", stamp[64] - stamp[0], 64 * MIN_T + 62 * SLOW_D);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule